// File: doc/BRIEF.md
# Boot Mode and Reset Sequencer

This block takes the chip from a power-on or pin reset to a released processor core with a known boot target. It watches an asynchronous active-low reset pin. A low level is accepted as a real reset only after it has lasted a minimum number of clock cycles, and shorter dips are filtered out as glitches. While the pin is low, or while a qualified reset is in force, every UART transmit lane is told to drive low.

When a qualified reset ends, the block samples the boot-select pin once. A high level sends the core straight to external flash. A low level opens a listening window on the UART receive byte stream. If the agreed sync byte arrives inside that window, the core is released into ROM download mode. If the window runs out first, the core falls back to external flash. The final target is held until the next qualified reset, and a one-cycle done pulse marks the moment the decision is made.

The receive side is a valid/ready byte stream. A byte transfers on a clock edge where both `rx_valid` and `rx_ready` are high. `rx_ready` is high only while the listening window is open, so there is no back-pressure inside the window: every byte offered there is consumed in the same cycle, and bytes other than the sync byte are thrown away. Outside the window `rx_ready` is low and nothing is consumed. A producer that holds `rx_valid` high against a low `rx_ready` is simply never served.

Top module: `boot_seq_top`

## Requirements
- R1: Two cycles after `rst_pin_n` goes low (synchronizer depth), and for as long as a qualified reset is in force, every bit of `txd_force_low` is 1. Once the core is released, every bit is 0.
- R2: A low pulse on `rst_pin_n` that covers fewer than `MIN_LOW_CYCLES` rising clock edges changes none of `core_release`, `boot_flash`, `rom_dl_mode`, and produces no `boot_done` pulse.
- R3: A low level covering `MIN_LOW_CYCLES` or more rising edges is a qualified reset. It drives `core_release`, `boot_flash`, `rom_dl_mode`, `boot_done` and `rx_ready` to 0, and a fresh boot sequence follows its release.
- R4: `boot_sel` is captured on the fourth rising edge after `rst_pin_n` returns high, and later changes are ignored. On the flash path, `boot_done` is high after the fifth rising edge.
- R5: When `boot_sel` is 1, the block releases the core with `boot_flash`=1 and `rom_dl_mode`=0, and pulses `boot_done`.
- R6: When `boot_sel` is 0, `rx_ready` is high for exactly `WINDOW_CYCLES` consecutive cycles, starting the cycle after the sample cycle, and `core_release` stays 0 during that time.
- R7: A transfer of the byte `SYNC_BYTE` (default 8'h55) while `rx_ready` is high ends the window on the next edge with `rom_dl_mode`=1, `boot_flash`=0, `core_release`=1 and a `boot_done` pulse.
- R8: Any other byte transferred in the window is consumed and discarded: the window stays open and no outputs change.
- R9: If no sync byte is transferred in the window, the edge that ends the window gives `boot_flash`=1, `rom_dl_mode`=0, `core_release`=1 and a `boot_done` pulse. A sync byte in the last window cycle wins over the timeout.
- R10: `boot_done` is high for exactly one cycle per boot. The target outputs then hold until the next qualified reset, and bytes offered after the window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin, synchronized and qualified inside |
| boot_sel | input | 1 | Boot select: 1 = external flash, 0 = ROM download path |
| rx_data | input | 8 | Received UART byte |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Byte accept, high only while the listening window is open |
| txd_force_low | output | TXD_LANES | Per UART lane: 1 forces the transmit pin low |
| boot_flash | output | 1 | Core boots from external flash |
| rom_dl_mode | output | 1 | Core boots into ROM download mode |
| core_release | output | 1 | Core may leave reset |
| boot_done | output | 1 | One-cycle pulse when the boot target is decided |

## Verification
The bench probes the exact edges of the reset filter. It sends a pulse one cycle short of the minimum, which a filter counting off by one would wrongly accept as a reset, and a pulse of exactly the minimum, which a filter comparing too late would ignore. It changes `boot_sel` right after the capture edge, so a design that keeps sampling the pin would flip its target. It measures the listening window to the cycle and sends the sync byte in its very last cycle, which catches a timeout that takes priority over the request or a window that is one cycle short. It also offers non-sync bytes inside the window and a sync byte after the window has closed, which expose a matcher that ignores the data value or a receive path left open after the decision.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_SAMPLE   = 3'd1,
    ST_FLASH    = 3'd2,
    ST_ROM_WAIT = 3'd3,
    ST_ROM_DL   = 3'd4,
    ST_FALLBACK = 3'd5
  } boot_state_e;

  function automatic logic is_final(boot_state_e s);
    return (s == ST_FLASH) || (s == ST_ROM_DL) || (s == ST_FALLBACK);
  endfunction

  function automatic logic is_flash_target(boot_state_e s);
    return (s == ST_FLASH) || (s == ST_FALLBACK);
  endfunction

endpackage

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 260000
) (
  input  logic clk,
  input  logic pin_n,
  output logic pin_level,
  output logic run_ok
);
  localparam int CW = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

  logic [SYNC_STAGES-1:0] chain;
  logic [CW-1:0]          low_cnt;

  always_ff @(posedge clk) begin
    chain <= {chain[SYNC_STAGES-2:0], pin_n};
  end

  assign pin_level = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (pin_level) begin
      low_cnt <= '0;
      run_ok  <= 1'b1;
    end else if (low_cnt == LAST) begin
      run_ok  <= 1'b0;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int LEN = 18200000
) (
  input  logic clk,
  input  logic clear,
  input  logic run,
  output logic last
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] END_VAL = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt <= '0;
    end else if (run && cnt != END_VAL) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = run && (cnt == END_VAL);

endmodule

// File: rtl/sync_byte_det.sv
module sync_byte_det #(
  parameter int              W     = 8,
  parameter logic [W-1:0]    MATCH = 8'h55
) (
  input  logic         open_win,
  input  logic [W-1:0] data,
  input  logic         valid,
  output logic         ready,
  output logic         hit
);
  assign ready = open_win;
  assign hit   = valid && open_win && (data == MATCH);
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int          MIN_LOW_CYCLES = 260000,
  parameter int          WINDOW_CYCLES  = 18200000,
  parameter logic [7:0]  SYNC_BYTE      = 8'h55,
  parameter int          SYNC_STAGES    = 2,
  parameter int          TXD_LANES      = 2
) (
  input  logic                 clk,
  input  logic                 rst_pin_n,
  input  logic                 boot_sel,
  input  logic [7:0]           rx_data,
  input  logic                 rx_valid,
  output logic                 rx_ready,
  output logic [TXD_LANES-1:0] txd_force_low,
  output logic                 boot_flash,
  output logic                 rom_dl_mode,
  output logic                 core_release,
  output logic                 boot_done
);

  logic        pin_level;
  logic        run_ok;
  logic        win_last;
  logic        sync_hit;
  logic        in_wait;
  logic        boot_sel_q;
  boot_state_e state, nxt;

  rst_qualifier #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_LOW     (MIN_LOW_CYCLES)
  ) u_qual (
    .clk       (clk),
    .pin_n     (rst_pin_n),
    .pin_level (pin_level),
    .run_ok    (run_ok)
  );

  assign in_wait = (state == ST_ROM_WAIT);

  window_timer #(
    .LEN (WINDOW_CYCLES)
  ) u_timer (
    .clk   (clk),
    .clear (!in_wait),
    .run   (in_wait),
    .last  (win_last)
  );

  sync_byte_det #(
    .W     (8),
    .MATCH (SYNC_BYTE)
  ) u_det (
    .open_win (in_wait),
    .data     (rx_data),
    .valid    (rx_valid),
    .ready    (rx_ready),
    .hit      (sync_hit)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:    nxt = ST_SAMPLE;
      ST_SAMPLE:   nxt = boot_sel_q ? ST_FLASH : ST_ROM_WAIT;
      ST_ROM_WAIT: begin
        if (sync_hit)      nxt = ST_ROM_DL;
        else if (win_last) nxt = ST_FALLBACK;
      end
      ST_FLASH, ST_ROM_DL, ST_FALLBACK: nxt = state;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!run_ok) begin
      state      <= ST_RESET;
      boot_sel_q <= 1'b0;
      boot_done  <= 1'b0;
    end else begin
      state     <= nxt;
      boot_done <= is_final(nxt) && !is_final(state);
      if (state == ST_RESET) boot_sel_q <= boot_sel;
    end
  end

  assign core_release = is_final(state);
  assign boot_flash   = is_flash_target(state);
  assign rom_dl_mode  = (state == ST_ROM_DL);

  for (genvar g = 0; g < TXD_LANES; g++) begin : g_txd
    assign txd_force_low[g] = !pin_level || !run_ok;
  end

endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             run_ok,
  input logic [LANES-1:0] txd_force_low,
  input logic             boot_done,
  input logic             core_release,
  input logic             boot_flash,
  input logic             rom_dl_mode,
  input logic             rx_ready
);

  always @(posedge clk) begin
    if (!run_ok) AST_TXD_HELD: assert (&txd_force_low) else $error("txd not held low in reset"); // R1
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!run_ok) boot_done |=> !boot_done) else $error("done wider than one cycle"); // R10
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!run_ok) boot_done |-> core_release) else $error("done without release"); // R5
  AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!run_ok) core_release |=> core_release) else $error("release dropped"); // R10
  AST_TARGET_EXCL: assert property (@(posedge clk) disable iff (!run_ok) $onehot0({boot_flash, rom_dl_mode})) else $error("two targets"); // R7
  AST_READY_CLOSED: assert property (@(posedge clk) disable iff (!run_ok) rx_ready |-> !core_release) else $error("ready after release"); // R6
  AST_RELEASE_TARGET: assert property (@(posedge clk) disable iff (!run_ok) core_release |-> (boot_flash || rom_dl_mode)) else $error("release with no target"); // R9

endmodule

bind boot_seq_top boot_seq_checker #(.LANES(TXD_LANES)) u_checker (
  .clk           (clk),
  .run_ok        (run_ok),
  .txd_force_low (txd_force_low),
  .boot_done     (boot_done),
  .core_release  (core_release),
  .boot_flash    (boot_flash),
  .rom_dl_mode   (rom_dl_mode),
  .rx_ready      (rx_ready)
);

// File: tb/test_boot_seq_top.sv
module test_boot_seq_top;
  localparam int         GL   = 16;
  localparam int         WIN  = 40;
  localparam logic [7:0] SYNC = 8'h55;

  logic       clk = 1'b0;
  logic       rst_pin_n = 1'b0;
  logic       boot_sel = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic       rx_ready, boot_flash, rom_dl_mode, core_release, boot_done;
  logic [1:0] txd_force_low;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  boot_seq_top #(
    .MIN_LOW_CYCLES (GL),
    .WINDOW_CYCLES  (WIN),
    .SYNC_BYTE      (SYNC),
    .SYNC_STAGES    (2),
    .TXD_LANES      (2)
  ) i_boot_seq_top (
    .clk           (clk),
    .rst_pin_n     (rst_pin_n),
    .boot_sel      (boot_sel),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .txd_force_low (txd_force_low),
    .boot_flash    (boot_flash),
    .rom_dl_mode   (rom_dl_mode),
    .core_release  (core_release),
    .boot_done     (boot_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic full_reset(input logic sel);
    boot_sel  = sel;
    rst_pin_n = 1'b0;
    repeat (GL + 8) tick();
    rst_pin_n = 1'b1;
  endtask

  task automatic wait_ready(output int found);
    found = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (rx_ready) begin
        found = 1;
        break;
      end
    end
  endtask

  task automatic t_reset_state();
    rst_pin_n = 1'b0;
    repeat (GL + 10) tick();
    chk("R1 txd forced in reset", txd_force_low, 3);
    chk("R3 core_release in reset", core_release, 0);
    chk("R3 boot_done in reset", boot_done, 0);
    chk("R3 boot_flash in reset", boot_flash, 0);
    chk("R3 rom_dl_mode in reset", rom_dl_mode, 0);
    chk("R3 rx_ready in reset", rx_ready, 0);
  endtask

  task automatic t_flash_boot();
    int lat;
    lat = 0;
    boot_sel  = 1'b1;
    rst_pin_n = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      tick();
      if (i == 4) boot_sel = 1'b0;
      if (boot_done) begin
        lat = i;
        break;
      end
    end
    chk("R4 done latency after release", lat, 5);
    chk("R4 boot_sel latched (flash kept)", boot_flash, 1);
    chk("R5 rom_dl_mode low on flash", rom_dl_mode, 0);
    chk("R5 core_release on flash", core_release, 1);
    chk("R1 txd released after boot", txd_force_low, 0);
    tick();
    chk("R10 done is one cycle", boot_done, 0);
    chk("R10 release holds", core_release, 1);
  endtask

  task automatic t_glitch();
    int drops, dones;
    drops = 0;
    dones = 0;
    rst_pin_n = 1'b0;
    tick();
    tick();
    chk("R1 txd forced while pin low", txd_force_low, 3);
    repeat (GL - 3) tick();
    rst_pin_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (!core_release || !boot_flash || rom_dl_mode) drops++;
      if (boot_done) dones++;
      tick();
    end
    chk("R2 short pulse keeps outputs", drops, 0);
    chk("R2 short pulse no done", dones, 0);
  endtask

  task automatic t_boundary();
    int saw_low, saw_ready;
    saw_low   = 0;
    saw_ready = 0;
    boot_sel  = 1'b0;
    rst_pin_n = 1'b0;
    repeat (GL) tick();
    rst_pin_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (!core_release) saw_low = 1;
      if (rx_ready) saw_ready = 1;
      tick();
    end
    chk("R3 minimum-length pulse resets", saw_low, 1);
    chk("R3 reboot after minimum pulse", saw_ready, 1);
  endtask

  task automatic t_rom_download();
    int found;
    full_reset(1'b0);
    wait_ready(found);
    chk("R6 window opens", found, 1);
    repeat (3) tick();
    send_byte(8'hAA);
    chk("R8 other byte keeps window", rx_ready, 1);
    chk("R8 other byte no done", boot_done, 0);
    chk("R6 no release in window", core_release, 0);
    tick();
    send_byte(SYNC);
    chk("R7 done on sync", boot_done, 1);
    chk("R7 rom_dl_mode", rom_dl_mode, 1);
    chk("R7 boot_flash low", boot_flash, 0);
    chk("R7 core_release", core_release, 1);
    chk("R7 window closed", rx_ready, 0);
  endtask

  task automatic t_rom_timeout();
    int found, len;
    full_reset(1'b0);
    wait_ready(found);
    len = 1;
    while (rx_ready && len < WIN + 10) begin
      if (len == 5 || len == 20) send_byte(8'h54);
      else tick();
      if (rx_ready) len++;
    end
    chk("R6 window length", len, WIN);
    chk("R9 fallback done", boot_done, 1);
    chk("R9 fallback boot_flash", boot_flash, 1);
    chk("R9 fallback rom_dl_mode", rom_dl_mode, 0);
    tick();
    send_byte(SYNC);
    chk("R10 late sync ignored rom_dl", rom_dl_mode, 0);
    chk("R10 late sync ignored flash", boot_flash, 1);
    chk("R10 late sync no done", boot_done, 0);
  endtask

  task automatic t_last_cycle();
    int found;
    full_reset(1'b0);
    wait_ready(found);
    repeat (WIN - 1) tick();
    chk("R6 still open in last cycle", rx_ready, 1);
    send_byte(SYNC);
    chk("R9 sync wins last cycle", rom_dl_mode, 1);
    chk("R9 last cycle done", boot_done, 1);
    chk("R9 last cycle not flash", boot_flash, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_flash_boot();
    t_glitch();
    t_boundary();
    t_rom_download();
    t_rom_timeout();
    t_last_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule